// File: doc/BRIEF.md
# Per-Timeslot Transmit Channel Conditioner

This block sits in the transmit payload path of a T1 framer. It handles one payload octet per valid strobe and carries a timeslot index from 0 to 23 with each octet. For each octet it looks up that timeslot's 4-bit conditioning code and produces an output octet. Depending on the code, the output is the input unchanged, the input XORed with a fixed mask, a fixed idle or alarm code, a per-timeslot user value, a busy code that carries the timeslot number, a digital milliwatt tone sample, a pseudo-random octet, or an octet taken from an auxiliary D/E-timeslot input.

Software programs the codes and user values through a small synchronous register port with a combinational read-back. The result is registered, so each output octet and its valid strobe appear one clock after the input.

Top module: `tx_chan_cond`

## Requirements
- R1: After reset, every timeslot code and every user value is 0, `out_valid` is 0 and `out_octet` is 0x00.
- R2: The code for timeslot t is written and read at address 0x300+t, using data bits 3:0; reads return 0 in bits 7:4. The user value for timeslot t is at 0x320+t, 8 bits wide. Writes to any other address have no effect, and reads of any other address return 0x00.
- R3: An octet accepted with `in_valid` high appears on `out_octet` one clock later, with `out_valid` high for exactly that clock. `out_valid` is low in every other cycle.
- R4: Codes 0x0 and 0xE pass the octet through unchanged. A timeslot index of 24 or higher always passes the octet through.
- R5: Code 0x1 XORs the octet with 0xFF, 0x2 with 0xAA, 0x3 with 0x55, 0xB with 0x80 and 0xC with 0x7F.
- R6: Code 0x4 outputs the user value of that timeslot.
- R7: Code 0x5 outputs 0x7F, code 0x6 outputs 0xFF and code 0x8 outputs 0x1A.
- R8: Code 0x7 outputs binary 111 in bits 7:5 and the 5-bit timeslot index in bits 4:0.
- R9: Code 0x9 outputs the A-law milliwatt octet at the current phase, from the sequence 34 21 21 34 B4 A1 A1 B4. Code 0xA outputs the mu-law octet, from the sequence 1E 0B 0B 1E 9E 8B 8B 9E. One 3-bit phase, starting at 0, is shared by both codes and advances by one after each octet of either code.
- R10: With `prbs_qrts` low, code 0xD outputs 8 bits of a 15-bit generator seeded with all ones. At each step the new bit is s[14]^s[13], it shifts in at s[0], and it is output. The first bit of the octet goes to bit 7.
- R11: With `prbs_qrts` high, code 0xD outputs 8 bits of a 20-bit generator seeded with all ones. At each step the raw bit is s[19]^s[16], and it shifts in at s[0]. The output bit is the raw bit, forced to 1 when that raw bit is a zero ending a run of 15 or more consecutive raw zeros. The first bit goes to bit 7.
- R12: Code 0xF outputs the octet on `de_octet` instead of the input octet.
- R13: Both generators advance 8 steps for every code-0xD octet, whatever the value of `prbs_qrts`, and hold at all other times. Octets with other codes leave the milliwatt phase and the generators unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational register read data |
| prbs_qrts | input | 1 | Selects the quasi-random source for code 0xD |
| in_valid | input | 1 | Input octet valid |
| in_ts | input | 5 | Timeslot index of the input octet |
| in_octet | input | 8 | Input payload octet |
| de_octet | input | 8 | Auxiliary D/E timeslot data |
| out_valid | output | 1 | Output octet valid |
| out_octet | output | 8 | Conditioned output octet |

## Verification
The assertions check on every cycle that the valid strobe follows the input by exactly one clock. They also check that pass-through, vacant and busy-with-timeslot octets come out with the right value, that the milliwatt phase steps only on milliwatt octets, and that the generators hold when no pseudo-random octet is taken and never reach the all-zero state. Only the bench scenarios show the actual register map, the exact milliwatt and pseudo-random octet sequences across interleaved timeslots, the XOR masks, the user and D/E substitutions, and the switch between the two random sources. The bench checks these against its own bit-serial model.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

  typedef enum logic [3:0] {
    C_PASS    = 4'h0, C_INV_ALL = 4'h1, C_INV_EVN = 4'h2, C_INV_ODD = 4'h3,
    C_USER    = 4'h4, C_BUSY    = 4'h5, C_VACANT  = 4'h6, C_BUSY_TS = 4'h7,
    C_MOOF    = 4'h8, C_MW_A    = 4'h9, C_MW_MU   = 4'hA, C_INV_MSB = 4'hB,
    C_INV_LOW = 4'hC, C_PRBS    = 4'hD, C_PASS2   = 4'hE, C_DE      = 4'hF
  } cond_code_e;

  typedef struct packed {
    logic [14:0] st;
    logic [7:0]  oct;
  } p15_res_t;

  typedef struct packed {
    logic [19:0] st;
    logic [3:0]  zrun;
    logic [7:0]  oct;
  } qr_res_t;

  function automatic p15_res_t p15_step8(input logic [14:0] s_in);
    p15_res_t r;
    logic b;
    r.st = s_in;
    r.oct = '0;
    for (int i = 7; i >= 0; i--) begin
      b = r.st[14] ^ r.st[13];
      r.st = {r.st[13:0], b};
      r.oct[i] = b;
    end
    return r;
  endfunction

  function automatic qr_res_t qr_step8(input logic [19:0] s_in, input logic [3:0] z_in);
    qr_res_t r;
    logic b;
    r.st = s_in;
    r.zrun = z_in;
    r.oct = '0;
    for (int i = 7; i >= 0; i--) begin
      b = r.st[19] ^ r.st[16];
      r.st = {r.st[18:0], b};
      if (b) r.zrun = 4'd0;
      else if (r.zrun != 4'hF) r.zrun = r.zrun + 4'd1;
      r.oct[i] = b | (r.zrun == 4'hF);
    end
    return r;
  endfunction

  function automatic logic [7:0] mw_octet(input logic alaw, input logic [2:0] ph);
    logic [6:0] mag;
    if (alaw) mag = (ph[1:0] == 2'd0 || ph[1:0] == 2'd3) ? 7'h34 : 7'h21;
    else      mag = (ph[1:0] == 2'd0 || ph[1:0] == 2'd3) ? 7'h1E : 7'h0B;
    return {ph[2], mag};
  endfunction

endpackage

// File: rtl/tcc_regfile.sv
module tcc_regfile #(
  parameter int unsigned NUM_TS = 24,
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned TS_W   = 5,
  parameter logic [ADDR_W-1:0] CODE_BASE = 'h300,
  parameter logic [ADDR_W-1:0] USER_BASE = 'h320
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [TS_W-1:0]   lk_ts,
  output logic [3:0]        lk_code,
  output logic [7:0]        lk_user
);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NUM_TS);

  logic [3:0] code_q [NUM_TS];
  logic [7:0] user_q [NUM_TS];

  logic [ADDR_W-1:0] code_off, user_off;
  logic code_hit, user_hit, lk_in_range;

  assign code_off = addr - CODE_BASE;
  assign user_off = addr - USER_BASE;
  assign code_hit = (addr >= CODE_BASE) && (code_off < SPAN);
  assign user_hit = (addr >= USER_BASE) && (user_off < SPAN);
  assign lk_in_range = (lk_ts < TS_W'(NUM_TS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_TS; i++) begin
        code_q[i] <= '0;
        user_q[i] <= '0;
      end
    end else if (we) begin
      if (code_hit) code_q[TS_W'(code_off)] <= wdata[3:0];
      if (user_hit) user_q[TS_W'(user_off)] <= wdata;
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (code_hit)      rdata = {4'h0, code_q[TS_W'(code_off)]};
    else if (user_hit) rdata = user_q[TS_W'(user_off)];
  end

  assign lk_code = lk_in_range ? code_q[lk_ts] : 4'h0;
  assign lk_user = lk_in_range ? user_q[lk_ts] : 8'h00;

endmodule

// File: rtl/tcc_mw_phase.sv
module tcc_mw_phase #(
  parameter int unsigned PH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  output logic [PH_W-1:0] phase
);
  always_ff @(posedge clk) begin
    if (!rst_n)    phase <= '0;
    else if (take) phase <= phase + PH_W'(1);
  end

  AST_MW_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> phase == $past(phase) + PH_W'(1)); // R9
  AST_MW_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(phase)); // R13
endmodule

// File: rtl/tcc_prbs.sv
module tcc_prbs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic       sel_qrts,
  output logic [7:0] octet
);
  import tcc_pkg::*;

  logic [14:0] p15_q;
  logic [19:0] qr_q;
  logic [3:0]  zrun_q;
  p15_res_t    p15_n;
  qr_res_t     qr_n;

  assign p15_n = p15_step8(p15_q);
  assign qr_n  = qr_step8(qr_q, zrun_q);
  assign octet = sel_qrts ? qr_n.oct : p15_n.oct;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p15_q  <= '1;
      qr_q   <= '1;
      zrun_q <= '0;
    end else if (take) begin
      p15_q  <= p15_n.st;
      qr_q   <= qr_n.st;
      zrun_q <= qr_n.zrun;
    end
  end

  AST_PRBS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(p15_q) && $stable(qr_q)); // R13
  AST_PRBS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (p15_q != '0) && (qr_q != '0)); // R10
endmodule

// File: rtl/tx_chan_cond.sv
module tx_chan_cond #(
  parameter int unsigned NUM_TS = 24,
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned TS_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              prbs_qrts,
  input  logic              in_valid,
  input  logic [TS_W-1:0]   in_ts,
  input  logic [7:0]        in_octet,
  input  logic [7:0]        de_octet,
  output logic              out_valid,
  output logic [7:0]        out_octet
);
  import tcc_pkg::*;

  localparam int unsigned PH_W = 3;

  logic [3:0]      lk_code;
  logic [7:0]      lk_user;
  cond_code_e      code;
  logic [PH_W-1:0] mw_ph;
  logic [7:0]      prbs_oct;
  logic            mw_take, prbs_take;
  logic [7:0]      cond_oct;
  logic [4:0]      ts5;

  tcc_regfile #(.NUM_TS(NUM_TS), .ADDR_W(ADDR_W), .TS_W(TS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .lk_ts(in_ts), .lk_code(lk_code), .lk_user(lk_user)
  );

  assign code      = cond_code_e'(lk_code);
  assign mw_take   = in_valid && (code == C_MW_A || code == C_MW_MU);
  assign prbs_take = in_valid && (code == C_PRBS);
  assign ts5       = 5'(in_ts);

  tcc_mw_phase #(.PH_W(PH_W)) u_mw (
    .clk(clk), .rst_n(rst_n), .take(mw_take), .phase(mw_ph)
  );

  tcc_prbs u_prbs (
    .clk(clk), .rst_n(rst_n), .take(prbs_take), .sel_qrts(prbs_qrts), .octet(prbs_oct)
  );

  always_comb begin
    unique case (code)
      C_INV_ALL: cond_oct = in_octet ^ 8'hFF;
      C_INV_EVN: cond_oct = in_octet ^ 8'hAA;
      C_INV_ODD: cond_oct = in_octet ^ 8'h55;
      C_USER:    cond_oct = lk_user;
      C_BUSY:    cond_oct = 8'h7F;
      C_VACANT:  cond_oct = 8'hFF;
      C_BUSY_TS: cond_oct = {3'b111, ts5};
      C_MOOF:    cond_oct = 8'h1A;
      C_MW_A:    cond_oct = mw_octet(1'b1, mw_ph);
      C_MW_MU:   cond_oct = mw_octet(1'b0, mw_ph);
      C_INV_MSB: cond_oct = in_octet ^ 8'h80;
      C_INV_LOW: cond_oct = in_octet ^ 8'h7F;
      C_PRBS:    cond_oct = prbs_oct;
      C_DE:      cond_oct = de_octet;
      default:   cond_oct = in_octet;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_octet <= 8'h00;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_octet <= cond_oct;
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R3
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R3
  AST_PASS_UNCHANGED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (lk_code == 4'h0 || lk_code == 4'hE)) |=> out_octet == $past(in_octet)); // R4
  AST_VACANT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lk_code == 4'h6) |=> out_octet == 8'hFF); // R7
  AST_BUSY_TS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lk_code == 4'h7) |=> out_octet == {3'b111, $past(ts5)}); // R8

endmodule

// File: tb/tx_chan_cond_test.sv
module tx_chan_cond_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [9:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       prbs_qrts = 1'b0;
  logic       in_valid = 1'b0;
  logic [4:0] in_ts = '0;
  logic [7:0] in_octet = '0;
  logic [7:0] de_octet = '0;
  logic       out_valid;
  logic [7:0] out_octet;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  logic [3:0]  m_code [24];
  logic [7:0]  m_user [24];
  logic [2:0]  m_ph = 3'd0;
  logic [14:0] m_p15 = '1;
  logic [19:0] m_q20 = '1;
  int          m_zeros = 0;

  logic [7:0] alaw_t [8] = '{8'h34, 8'h21, 8'h21, 8'h34, 8'hB4, 8'hA1, 8'hA1, 8'hB4};
  logic [7:0] mulaw_t[8] = '{8'h1E, 8'h0B, 8'h0B, 8'h1E, 8'h9E, 8'h8B, 8'h8B, 8'h9E};

  always #(CLK_P/2) clk = ~clk;

  tx_chan_cond uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .prbs_qrts(prbs_qrts),
    .in_valid(in_valid), .in_ts(in_ts), .in_octet(in_octet), .de_octet(de_octet),
    .out_valid(out_valid), .out_octet(out_octet)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input string req, input logic [9:0] a, input logic [7:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1 check(req, reg_rdata, exp);
  endtask

  function automatic logic [7:0] prbs_model();
    logic [7:0] a = '0, b = '0;
    logic bit_p, bit_q;
    for (int k = 0; k < 8; k++) begin
      bit_p = m_p15[14] ^ m_p15[13];
      m_p15 = {m_p15[13:0], bit_p};
      a = {a[6:0], bit_p};
      bit_q = m_q20[19] ^ m_q20[16];
      m_q20 = {m_q20[18:0], bit_q};
      m_zeros = bit_q ? 0 : m_zeros + 1;
      b = {b[6:0], bit_q | (m_zeros >= 15)};
    end
    return prbs_qrts ? b : a;
  endfunction

  task automatic send(input logic [4:0] ts, input logic [7:0] d, input logic [7:0] aux);
    logic [7:0] e;
    string t;
    logic [3:0] c;
    @(negedge clk);
    in_valid = 1'b1; in_ts = ts; in_octet = d; de_octet = aux;
    c = (ts < 24) ? m_code[ts] : 4'h0;
    case (c)
      4'h1: begin e = ~d;             t = "R5 inv-all"; end
      4'h2: begin e = d ^ 8'b10101010; t = "R5 inv-even"; end
      4'h3: begin e = d ^ 8'b01010101; t = "R5 inv-odd"; end
      4'hB: begin e = {~d[7], d[6:0]}; t = "R5 inv-msb"; end
      4'hC: begin e = {d[7], ~d[6:0]}; t = "R5 inv-low"; end
      4'h4: begin e = m_user[ts];     t = "R6 user"; end
      4'h5: begin e = 8'h7F;          t = "R7 busy"; end
      4'h6: begin e = 8'hFF;          t = "R7 vacant"; end
      4'h8: begin e = 8'h1A;          t = "R7 moof"; end
      4'h7: begin e = 8'hE0 | 8'(ts); t = "R8 busy-ts"; end
      4'h9: begin e = alaw_t[m_ph];  m_ph = m_ph + 3'd1; t = "R9 a-law"; end
      4'hA: begin e = mulaw_t[m_ph]; m_ph = m_ph + 3'd1; t = "R9 mu-law"; end
      4'hD: begin e = prbs_model(); t = prbs_qrts ? "R11 qrts R13" : "R10 prbs15 R13"; end
      4'hF: begin e = aux;            t = "R12 de"; end
      default: begin e = d;           t = "R4 pass"; end
    endcase
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (rst_n && out_valid) begin
        if (exp_q.size() == 0) begin
          check("R3 unexpected valid", 8'h01, 8'h00);
        end else begin
          check(tag_q.pop_front(), out_octet, exp_q.pop_front());
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    for (int i = 0; i < 24; i++) begin m_code[i] = 4'h0; m_user[i] = 8'h00; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 out_valid", {7'd0, out_valid}, 8'h00);
    check("R1 out_octet", out_octet, 8'h00);
    reg_rd("R1 code reset", 10'h305, 8'h00);
    reg_rd("R1 user reset", 10'h337, 8'h00);
    send(5'd3, 8'h5C, 8'h00);
    idle(1);

    for (int i = 0; i < 24; i++) begin
      logic [3:0] c;
      c = (i < 16) ? 4'(i) : ((i == 16 || i == 22) ? 4'hD : (i == 17) ? 4'h9 :
          (i == 18) ? 4'hA : (i == 19) ? 4'h7 : (i == 20) ? 4'hF : (i == 21) ? 4'h4 : 4'hE);
      reg_wr(10'h300 + 10'(i), {4'hA, c});
      m_code[i] = c;
      reg_wr(10'h320 + 10'(i), 8'hC0 + 8'(i));
      m_user[i] = 8'hC0 + 8'(i);
    end
    reg_rd("R2 code read masks high bits", 10'h30C, 8'h0C);
    reg_rd("R2 code last", 10'h317, 8'h0E);
    reg_rd("R2 user first", 10'h320, 8'hC0);
    reg_rd("R2 user last", 10'h337, 8'hD7);
    reg_wr(10'h318, 8'h3C);
    reg_rd("R2 hole after codes", 10'h318, 8'h00);
    reg_wr(10'h338, 8'h3C);
    reg_rd("R2 hole after users", 10'h338, 8'h00);
    reg_rd("R2 neighbour untouched", 10'h337, 8'hD7);

    for (int f = 0; f < 3; f++) begin
      for (int i = 0; i < 24; i++) send(5'(i), 8'(i * 37 + f * 11 + 5), 8'(i * 13 + f));
      idle(f);
    end
    send(5'd30, 8'h81, 8'h00);
    send(5'd24, 8'h00, 8'h00);
    idle(2);

    for (int k = 0; k < 10; k++) begin
      send(5'd17, 8'h00, 8'h00);
      send(5'd18, 8'h00, 8'h00);
      send(5'd2, 8'h33, 8'h00);
    end
    idle(1);

    prbs_qrts = 1'b1;
    for (int k = 0; k < 12; k++) begin
      send(5'd16, 8'h00, 8'h00);
      send(5'd0, 8'h99, 8'h00);
    end
    idle(1);
    prbs_qrts = 1'b0;
    for (int k = 0; k < 6; k++) send(5'd22, 8'h00, 8'h00);
    idle(4);

    check("R3 queue drained", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule